// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits at the head of a receive path and looks only at the destination address: the first six bytes of each incoming frame. From those bytes, a receive mode word, a programmed station address and a 64-bit multicast hash table, it decides whether the frame should be kept or thrown away. It also reports whether the address is a group address.

A pulse on `frame_start` restarts the filter for a new frame. Address bytes then arrive one per cycle whenever `byte_valid` is high, with idle cycles allowed between them. While the bytes arrive, the filter folds each one into a CRC-32. It also checks each byte against all-ones and against the station address. One cycle after the sixth byte is taken, the filter raises a one-cycle decision strobe. Bytes that come after the sixth are ignored until the next frame start.

The station address and the hash table are set and read back through a small byte-wide register port. The mode word is a plain input.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` is low and every register offset reads 0.
- R2: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth address byte since the last `frame_start`. Further bytes produce no new strobe until the next `frame_start`.
- R3: When `cfg` bit 4 is set, every frame is accepted.
- R4: An address whose six bytes are all 0xFF is broadcast. With `cfg` bit 4 clear, a broadcast address is accepted exactly when `cfg` bit 2 is set.
- R5: An address that is not broadcast and has bit 0 of its first byte set is multicast. With `cfg` bits 4 and 3 both clear, a multicast address is rejected.
- R6: With `cfg` bit 3 set, a multicast address is filtered through the hash table. The CRC-32 is computed over the six bytes with reflected polynomial 0xEDB88320, a starting value of all ones, each byte taken LSB first, and no final inversion. Bits 31..26 of that CRC form an index. The frame is accepted exactly when bit (index mod 8) of hash byte (index / 8) is set.
- R7: Any other address is accepted exactly when byte k of the address (k = 0 being the first byte received) equals the station byte at register offset 1+k, for all six k.
- R8: `dec_group` equals bit 0 of the first address byte. It is driven only while `dec_valid` is high and is 0 otherwise.
- R9: A write to offsets 1..6 sets station bytes. A write to offsets 8..15 sets hash byte (offset-8). These offsets read back the last value written. Offsets 0 and 7 read 0, and writes to them change nothing.
- R10: A `frame_start` restarts the address count, including in the middle of an address. A byte presented in the same cycle as `frame_start` counts as the first byte of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 8 | Receive mode: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Incoming frame byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with `dec_valid`) |
| dec_group | output | 1 | Group-address flag (valid with `dec_valid`) |

## Verification
The hardest case to reach from the ports is a multicast frame whose acceptance depends on one particular hash bit. Random multicast addresses land on hash indices that the stimulus does not control.

The bench handles this with directed tests. It computes the index of a chosen multicast address on its own and sets only that hash bit, which must give an accept. It then sets every hash bit except that one, which must give a reject. This is followed by random frames with random hash tables, random gaps between bytes, and frames that restart in the middle of an address.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       frame_start,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       dec_valid,
  output logic       dec_accept,
  output logic       dec_group
);
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic [7:0]  sta  [8];
  logic [7:0]  hash [8];
  logic [2:0]  cnt;
  logic [31:0] crc;
  logic        all_ones, sta_eq, grp, done;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [2:0]  b_cnt;
  logic [31:0] b_crc;
  logic        b_ones, b_eq, take;
  assign b_cnt  = frame_start ? 3'd0 : cnt;
  assign b_crc  = frame_start ? 32'hFFFFFFFF : crc;
  assign b_ones = frame_start ? 1'b1 : all_ones;
  assign b_eq   = frame_start ? 1'b1 : sta_eq;
  assign take   = byte_valid && (b_cnt < 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= 3'd6;
      crc      <= 32'hFFFFFFFF;
      all_ones <= 1'b0;
      sta_eq   <= 1'b0;
      grp      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= take && (b_cnt == 3'd5);
      if (frame_start) begin
        cnt      <= 3'd0;
        crc      <= 32'hFFFFFFFF;
        all_ones <= 1'b1;
        sta_eq   <= 1'b1;
        grp      <= 1'b0;
      end
      if (take) begin
        cnt      <= b_cnt + 3'd1;
        crc      <= crc_step(b_crc, byte_data);
        all_ones <= b_ones && (byte_data == 8'hFF);
        sta_eq   <= b_eq && (byte_data == sta[b_cnt]);
        if (b_cnt == 3'd0) grp <= byte_data[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        sta[i]  <= 8'h00;
        hash[i] <= 8'h00;
      end
    end else if (reg_wr) begin
      if (reg_addr[3])
        hash[reg_addr[2:0]] <= reg_wdata;
      else if (reg_addr[2:0] != 3'd0 && reg_addr[2:0] != 3'd7)
        sta[reg_addr[2:0] - 3'd1] <= reg_wdata;
    end
  end

  always_comb begin
    if (reg_addr[3])
      reg_rdata = hash[reg_addr[2:0]];
    else if (reg_addr[2:0] != 3'd0 && reg_addr[2:0] != 3'd7)
      reg_rdata = sta[reg_addr[2:0] - 3'd1];
    else
      reg_rdata = 8'h00;
  end

  logic [5:0] idx;
  logic       hit, accept;
  assign idx    = crc[31:26];
  assign hit    = hash[idx[5:3]][idx[2:0]];
  assign accept = cfg[4] | (all_ones ? cfg[2] : (grp ? (cfg[3] & hit) : sta_eq));

  assign dec_valid  = done;
  assign dec_accept = done & accept;
  assign dec_group  = done & grp;

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid));
  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg[4]) |-> dec_accept);
  p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg[4] && !cfg[2] && all_ones) |-> !dec_accept);
  p_mcast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg[4] && !cfg[3] && dec_group && !all_ones) |-> !dec_accept);
  p_group_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_group);
  p_hash_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[3]) |=> (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg = 0;
  logic frame_start = 0, byte_valid = 0;
  logic [7:0] byte_data = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic dec_valid, dec_accept, dec_group;

  int checks = 0, fails = 0;
  logic [7:0] m_sta [6];
  logic [7:0] m_hash [8];

  always #4 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (.*);

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] m_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++)
      c = (c[0] ^ a[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c[31:26];
  endfunction

  function automatic logic m_accept(input logic [7:0] c, input logic [47:0] a);
    logic [5:0] ix;
    if (c[4]) return 1'b1;
    if (a == '1) return c[2];
    if (a[0]) begin
      ix = m_idx(a);
      return c[3] && m_hash[ix[5:3]][ix[2:0]];
    end
    for (int k = 0; k < 6; k++) if (a[8*k +: 8] != m_sta[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a >= 4'd1 && a <= 4'd6) m_sta[a-1] = d;
    if (a[3]) m_hash[a[2:0]] = d;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic send(input string tag, input logic [47:0] a, input bit gaps, input bit fs_with_byte);
    @(negedge clk);
    if (!fs_with_byte) begin
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
    end
    for (int k = 0; k < 6; k++) begin
      if (gaps) repeat ($urandom_range(0, 2)) begin
        byte_valid = 0;
        @(negedge clk);
        chk({tag, " R2 early"}, dec_valid, 0);
      end
      byte_valid = 1; byte_data = a[8*k +: 8];
      frame_start = fs_with_byte && (k == 0);
      @(negedge clk);
      frame_start = 0;
      if (k < 5) chk({tag, " R2 early"}, dec_valid, 0);
    end
    byte_valid = 0;
    chk({tag, " R2 valid"}, dec_valid, 1);
    chk({tag, " R3-R7 accept"}, dec_accept, m_accept(cfg, a));
    chk({tag, " R8 group"}, dec_group, a[0]);
    byte_valid = 1; byte_data = 8'hFF;
    @(negedge clk);
    chk({tag, " R2 single"}, dec_valid, 0);
    @(negedge clk);
    byte_valid = 0;
    chk({tag, " R2 extra ignored"}, dec_valid, 0);
    chk({tag, " R8 group quiet"}, dec_group, 0);
  endtask

  initial begin
    logic [47:0] sta_a, mc;
    logic [5:0] ix;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 6; i++) m_sta[i] = 0;
    for (int i = 0; i < 8; i++) m_hash[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 dec_valid", dec_valid, 0);
    for (int a = 0; a < 16; a++) rd("R1 reg reset", 4'(a), 8'h00);

    sta_a = 48'h5634_1200_AB02;
    for (int k = 0; k < 6; k++) wr(4'(k + 1), sta_a[8*k +: 8]);
    wr(4'd0, 8'h77); wr(4'd7, 8'h99);
    for (int k = 0; k < 6; k++) rd("R9 station readback", 4'(k + 1), sta_a[8*k +: 8]);
    rd("R9 offset 0 reads 0", 4'd0, 8'h00);
    rd("R9 offset 7 reads 0", 4'd7, 8'h00);
    for (int j = 0; j < 8; j++) wr(4'(8 + j), 8'(j * 37 + 5));
    for (int j = 0; j < 8; j++) rd("R9 hash readback", 4'(8 + j), 8'(j * 37 + 5));

    cfg = 8'h00;
    send("R7 station match", sta_a, 0, 0);
    send("R7 station mismatch", sta_a ^ 48'h0100_0000_0000, 0, 0);
    send("R4 bcast off", '1, 0, 0);
    cfg = 8'h04;
    send("R4 bcast on", '1, 0, 0);
    cfg = 8'h00;
    mc = 48'h0000_5E00_0001;
    send("R5 mcast disabled", mc, 0, 0);
    cfg = 8'h10;
    send("R3 promisc", 48'h1122_3344_5566, 1, 0);

    cfg = 8'h08;
    ix = m_idx(mc);
    for (int j = 0; j < 8; j++) wr(4'(8 + j), (j == ix[5:3]) ? 8'(1 << ix[2:0]) : 8'h00);
    send("R6 hash bit set", mc, 0, 0);
    for (int j = 0; j < 8; j++) wr(4'(8 + j), (j == ix[5:3]) ? ~8'(1 << ix[2:0]) : 8'hFF);
    send("R6 hash bit clear", mc, 0, 0);

    cfg = 8'h00;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int k = 0; k < 3; k++) begin
      byte_valid = 1; byte_data = 8'hEE;
      @(negedge clk);
    end
    byte_valid = 0;
    send("R10 restart same cycle", sta_a, 0, 1);

    for (int n = 0; n < 300; n++) begin
      logic [47:0] a;
      cfg = 8'($urandom) & 8'h1C;
      if (n % 20 == 0)
        for (int j = 0; j < 8; j++) wr(4'(8 + j), 8'($urandom));
      case ($urandom_range(0, 3))
        0: a = sta_a;
        1: a = '1;
        2: a = {16'($urandom), 32'($urandom)} | 48'h1;
        default: a = {16'($urandom), 32'($urandom)} & ~48'h1;
      endcase
      send("R3-R8 random", a, 1, n % 7 == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule